// File: doc/BRIEF.md
# Reset and Power-Mode Sequencer

This block decides when a small 8-bit controller core runs, sleeps or halts, and when it is held in reset. It runs on the raw oscillator clock. From that clock it derives clock enables at half the oscillator rate: one for the CPU and one for the peripherals (RAM, timers, serial port, interrupt logic). A raw reset pin passes through a synchroniser and a filter. Only a pin held high for two full machine cycles of twelve oscillator clocks asserts the internal reset.

Software can request a light sleep, in which the CPU enable stops and the peripheral enable keeps running. It can also request a deep halt, in which the oscillator-run enable drops and both clock enables stop. The light sleep ends on an enabled interrupt or on a reset. The deep halt ends only on a reset. The reset pin restarts the oscillator directly, because the synchroniser cannot clock while the oscillator is stopped. When a reset ends the light sleep, the CPU resumes for a short time before the internal reset takes over. RAM writes are blocked during that time.

The block also keeps a copy of the external-access strap. When the lock-bit-1 setting is programmed, this copy is taken during reset, and a flag shows when the copy disagrees with the live pin.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: Outside reset, in run mode, `cpu_clk_en` and `per_clk_en` are high on alternate oscillator cycles, never on two consecutive ones.
- R2: `int_rst` goes high on the 26th rising oscillator edge after `rst_pin_a` rises (2 synchroniser stages plus 24 clocks). A high pulse of 20 clocks never asserts `int_rst`. After the pin falls, `int_rst` drops on the 3rd edge.
- R3: While `int_rst` is high, both clock enables are low and `osc_run` is high. After reset the mode is run.
- R4: A one-cycle `idle_req` in run mode stops `cpu_clk_en` from the next edge on, while `per_clk_en` keeps alternating. A one-cycle `irq_pending` in that mode returns to run.
- R5: A one-cycle `pd_req` in run mode drives `osc_run`, `cpu_clk_en` and `per_clk_en` low. `irq_pending` and `idle_req` are then ignored. A high `rst_pin_a` raises `osc_run` at once, without waiting for a clock, and the completed reset returns to run.
- R6: When `idle_req` and `pd_req` are high in the same cycle, power-down is entered.
- R7: When the synchronised reset is seen in idle mode, the block leaves idle and `ram_wr_block` goes high from the 3rd edge after the pin rises. It goes low when `int_rst` rises. A reset pulse in run mode never raises `ram_wr_block`.
- R8: During `int_rst`, `ea_latched` takes `ea_pin` only when `lock1_prog` is 1. Otherwise `ea_latched` keeps its value.
- R9: `ea_mismatch` is 1 exactly when `lock1_prog` is 1 and `ea_latched` differs from `ea_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock |
| rst_pin_a | input | 1 | Asynchronous reset pin, active high |
| idle_req | input | 1 | Software request for idle mode |
| pd_req | input | 1 | Software request for power-down |
| irq_pending | input | 1 | An enabled interrupt is pending |
| ea_pin | input | 1 | External-access strap pin |
| lock1_prog | input | 1 | Lock bit 1 is programmed |
| cpu_clk_en | output | 1 | CPU clock enable (half oscillator rate) |
| per_clk_en | output | 1 | Peripheral clock enable (half oscillator rate) |
| osc_run | output | 1 | Oscillator run enable |
| int_rst | output | 1 | Filtered internal reset |
| ram_wr_block | output | 1 | Internal RAM write inhibit |
| ea_latched | output | 1 | Latched external-access value |
| ea_mismatch | output | 1 | Latched value disagrees with the live pin |

## Verification
The assertions check the following on every cycle outside reset:
- The CPU enable never stays high for two cycles in a row.
- Interrupts wake the core from idle.
- Power-down is left only through reset, and it wins over an idle request made in the same cycle.
- A reset seen in idle raises the RAM write inhibit.
- The latched strap holds still outside reset.

The exact reset filter timing can only be shown by the bench's scenarios, for both the 26-edge assertion and the 20-clock pulse that is rejected. The same holds for the immediate oscillator restart from the pin, the window in which the inhibit is high, and the lock-bit-dependent capture of the strap.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2
  } pmode_t;
endpackage

// File: rtl/prc_rst_filter.sv
module prc_rst_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CLKS    = 24
) (
  input  logic clk,
  input  logic rst_pin_a,
  output logic rst_sync,
  output logic int_rst
);
  localparam int CW = $clog2(RST_CLKS + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_CLKS);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk) sync_q[0] <= rst_pin_a;

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) sync_q[g] <= sync_q[g-1];
  end

  assign rst_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_sync)        cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign int_rst = (cnt_q == LIM);
endmodule

// File: rtl/prc_mode_fsm.sv
module prc_mode_fsm
  import prc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_pin_a,
  input  logic   rst_sync,
  input  logic   int_rst,
  input  logic   idle_req,
  input  logic   pd_req,
  input  logic   irq_pending,
  output pmode_t mode,
  output logic   cpu_clk_en,
  output logic   per_clk_en,
  output logic   osc_run,
  output logic   ram_wr_block
);
  pmode_t mode_q, mode_d;
  logic   phase_q;
  logic   blk_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (pd_req)        mode_d = MODE_PD;
        else if (idle_req) mode_d = MODE_IDLE;
      end
      MODE_IDLE: begin
        if (rst_sync || irq_pending) mode_d = MODE_RUN;
      end
      MODE_PD:  mode_d = MODE_PD;
      default:  mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (int_rst) begin
      mode_q  <= MODE_RUN;
      phase_q <= 1'b0;
      blk_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      phase_q <= ~phase_q;
      if (!rst_sync)                            blk_q <= 1'b0;
      else if (mode_q == MODE_IDLE)             blk_q <= 1'b1;
    end
  end

  assign mode         = mode_q;
  assign cpu_clk_en   = phase_q & ~int_rst & (mode_q == MODE_RUN);
  assign per_clk_en   = phase_q & ~int_rst & (mode_q != MODE_PD);
  assign osc_run      = (mode_q != MODE_PD) | rst_pin_a;
  assign ram_wr_block = blk_q & ~int_rst;
endmodule

// File: rtl/prc_ea_latch.sv
module prc_ea_latch (
  input  logic clk,
  input  logic int_rst,
  input  logic lock1_prog,
  input  logic ea_pin,
  output logic ea_latched,
  output logic ea_mismatch
);
  logic ea_q;

  always_ff @(posedge clk) begin
    if (int_rst && lock1_prog) ea_q <= ea_pin;
  end

  assign ea_latched  = ea_q;
  assign ea_mismatch = lock1_prog & (ea_q ^ ea_pin);
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import prc_pkg::*;
#(
  parameter int OSC_PER_MC  = 12,
  parameter int RST_MCS     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic rst_pin_a,
  input  logic idle_req,
  input  logic pd_req,
  input  logic irq_pending,
  input  logic ea_pin,
  input  logic lock1_prog,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_run,
  output logic int_rst,
  output logic ram_wr_block,
  output logic ea_latched,
  output logic ea_mismatch
);
  localparam int RST_CLKS = OSC_PER_MC * RST_MCS;

  logic   rst_sync;
  pmode_t mode;

  prc_rst_filter #(.SYNC_STAGES(SYNC_STAGES), .RST_CLKS(RST_CLKS)) u_filt (
    .clk(osc_clk), .rst_pin_a(rst_pin_a), .rst_sync(rst_sync), .int_rst(int_rst)
  );

  prc_mode_fsm u_fsm (
    .clk(osc_clk), .rst_pin_a(rst_pin_a), .rst_sync(rst_sync), .int_rst(int_rst),
    .idle_req(idle_req), .pd_req(pd_req), .irq_pending(irq_pending),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_run(osc_run), .ram_wr_block(ram_wr_block)
  );

  prc_ea_latch u_ea (
    .clk(osc_clk), .int_rst(int_rst), .lock1_prog(lock1_prog), .ea_pin(ea_pin),
    .ea_latched(ea_latched), .ea_mismatch(ea_mismatch)
  );
endmodule

// File: rtl/prc_checker.sv
module prc_checker
  import prc_pkg::*;
(
  input logic   clk,
  input logic   int_rst,
  input logic   rst_sync,
  input pmode_t mode,
  input logic   idle_req,
  input logic   pd_req,
  input logic   irq_pending,
  input logic   cpu_clk_en,
  input logic   per_clk_en,
  input logic   osc_run,
  input logic   ram_wr_block,
  input logic   ea_latched
);
  AST_CPU_EN_ALTERNATES: assert property (@(posedge clk) disable iff (int_rst)
    cpu_clk_en |=> !cpu_clk_en); // R1
  AST_PER_EN_ALTERNATES: assert property (@(posedge clk) disable iff (int_rst)
    per_clk_en |=> !per_clk_en); // R1
  AST_IDLE_IRQ_WAKES: assert property (@(posedge clk) disable iff (int_rst)
    (mode == MODE_IDLE && irq_pending) |=> (mode == MODE_RUN)); // R4
  AST_IDLE_CPU_STOPPED: assert property (@(posedge clk) disable iff (int_rst)
    (mode == MODE_IDLE) |-> !cpu_clk_en); // R4
  AST_PD_HELD: assert property (@(posedge clk) disable iff (int_rst)
    (mode == MODE_PD) |=> (mode == MODE_PD)); // R5
  AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (int_rst)
    (!osc_run) |-> (!cpu_clk_en && !per_clk_en)); // R5
  AST_PD_WINS: assert property (@(posedge clk) disable iff (int_rst)
    (mode == MODE_RUN && pd_req && idle_req) |=> (mode == MODE_PD)); // R6
  AST_IDLE_RST_BLOCKS: assert property (@(posedge clk) disable iff (int_rst)
    (mode == MODE_IDLE && rst_sync) |=> ram_wr_block); // R7
  AST_EA_STABLE: assert property (@(posedge clk) disable iff (int_rst)
    1'b1 |=> $stable(ea_latched)); // R8
endmodule

bind pwr_rst_ctrl prc_checker i_chk (
  .clk(osc_clk), .int_rst(int_rst), .rst_sync(rst_sync), .mode(mode),
  .idle_req(idle_req), .pd_req(pd_req), .irq_pending(irq_pending),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
  .ram_wr_block(ram_wr_block), .ea_latched(ea_latched)
);

// File: tb/test_pwr_rst_ctrl.sv
module test_pwr_rst_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic osc_clk = 1'b0;
  logic rst_pin_a = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq_pending = 1'b0;
  logic ea_pin = 1'b1, lock1_prog = 1'b1;
  logic cpu_clk_en, per_clk_en, osc_run, int_rst, ram_wr_block, ea_latched, ea_mismatch;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

  pwr_rst_ctrl i_pwr_rst_ctrl (
    .osc_clk(osc_clk), .rst_pin_a(rst_pin_a), .idle_req(idle_req), .pd_req(pd_req),
    .irq_pending(irq_pending), .ea_pin(ea_pin), .lock1_prog(lock1_prog),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
    .int_rst(int_rst), .ram_wr_block(ram_wr_block), .ea_latched(ea_latched),
    .ea_mismatch(ea_mismatch)
  );

  always @(posedge osc_clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  // count enable highs over two consecutive cycles
  task automatic two(output int c, output int p);
    c = 0; p = 0;
    for (int i = 0; i < 2; i++) begin
      step(1);
      c += int'(cpu_clk_en); p += int'(per_clk_en);
    end
  endtask

  task automatic full_reset();
    rst_pin_a = 1'b1; step(26);
    rst_pin_a = 1'b0; step(3);
  endtask

  task automatic t_power_on();
    int c, p;
    rst_pin_a = 1'b1; step(25);
    chk(int_rst == 1'b0, "R2 not before 26 edges", int'(int_rst), 0);
    step(1);
    chk(int_rst == 1'b1, "R2 asserted at 26", int'(int_rst), 1);
    chk(!cpu_clk_en && !per_clk_en, "R3 enables low in reset", int'(cpu_clk_en|per_clk_en), 0);
    chk(osc_run == 1'b1, "R3 osc runs in reset", int'(osc_run), 1);
    rst_pin_a = 1'b0; step(2);
    chk(int_rst == 1'b1, "R2 held 2 edges after release", int'(int_rst), 1);
    step(1);
    chk(int_rst == 1'b0, "R2 released at 3rd edge", int'(int_rst), 0);
    chk(ea_latched == 1'b1, "R8 strap captured with lock1", int'(ea_latched), 1);
    chk(ea_mismatch == 1'b0, "R9 no mismatch", int'(ea_mismatch), 0);
    for (int k = 0; k < 3; k++) begin
      two(c, p);
      chk(c == 1, "R1 cpu enable alternates", c, 1);
      chk(p == 1, "R1 per enable alternates", p, 1);
    end
  endtask

  task automatic t_short_pulse();
    int seen = 0;
    rst_pin_a = 1'b1;
    for (int i = 0; i < 20; i++) begin step(1); seen += int'(int_rst) + int'(ram_wr_block); end
    rst_pin_a = 1'b0;
    for (int i = 0; i < 10; i++) begin step(1); seen += int'(int_rst) + int'(ram_wr_block); end
    chk(seen == 0, "R2 R7 short pulse ignored, no block in run", seen, 0);
  endtask

  task automatic t_idle();
    int c, p;
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    two(c, p);
    chk(c == 0, "R4 cpu stopped in idle", c, 0);
    chk(p == 1, "R4 per running in idle", p, 1);
    irq_pending = 1'b1; step(1); irq_pending = 1'b0;
    two(c, p);
    chk(c == 1, "R4 irq wakes cpu", c, 1);
  endtask

  task automatic t_pd();
    int c, p;
    idle_req = 1'b1; pd_req = 1'b1; step(1); idle_req = 1'b0; pd_req = 1'b0;
    chk(osc_run == 1'b0, "R6 pd wins over idle", int'(osc_run), 0);
    two(c, p);
    chk(c + p == 0, "R5 enables off in pd", c + p, 0);
    irq_pending = 1'b1; step(1); irq_pending = 1'b0;
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    step(2);
    chk(osc_run == 1'b0, "R5 irq and idle ignored in pd", int'(osc_run), 0);
    #1 rst_pin_a = 1'b1; #1;
    chk(osc_run == 1'b1, "R5 pin restarts osc at once", int'(osc_run), 1);
    step(26);
    rst_pin_a = 1'b0; step(3);
    two(c, p);
    chk(c == 1 && p == 1, "R5 back to run after reset", c, 1);
  endtask

  task automatic t_idle_reset();
    int c, p;
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    rst_pin_a = 1'b1; step(2);
    chk(ram_wr_block == 1'b0, "R7 no block before sync", int'(ram_wr_block), 0);
    step(1);
    chk(ram_wr_block == 1'b1, "R7 block at 3rd edge", int'(ram_wr_block), 1);
    two(c, p);
    chk(c == 1, "R7 cpu resumes after idle exit by reset", c, 1);
    step(20);
    chk(ram_wr_block == 1'b1 && int_rst == 1'b0, "R7 block held to 25", int'(ram_wr_block), 1);
    step(1);
    chk(ram_wr_block == 1'b0 && int_rst == 1'b1, "R7 block drops at int_rst", int'(ram_wr_block), 0);
    rst_pin_a = 1'b0; step(3);
  endtask

  task automatic t_ea();
    ea_pin = 1'b0; step(1);
    chk(ea_mismatch == 1'b1, "R9 mismatch with lock1", int'(ea_mismatch), 1);
    lock1_prog = 1'b0; step(1);
    chk(ea_mismatch == 1'b0, "R9 no mismatch without lock1", int'(ea_mismatch), 0);
    full_reset();
    chk(ea_latched == 1'b1, "R8 no capture without lock1", int'(ea_latched), 1);
    lock1_prog = 1'b1; full_reset();
    chk(ea_latched == 1'b0, "R8 capture with lock1", int'(ea_latched), 0);
    chk(ea_mismatch == 1'b0, "R9 agree after capture", int'(ea_mismatch), 0);
  endtask

  initial begin
    step(2);
    t_power_on();
    t_short_pulse();
    t_idle();
    t_pd();
    t_idle_reset();
    t_ea();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule